// File: doc/BRIEF.md
# Masked Beam-Position Comparator

This block decides whether a display-list wait or skip condition holds. It takes the two 16-bit words of a wait/skip instruction, the current 8-bit vertical and horizontal beam counters and a flag saying the blitter has finished. From these it produces one bit that tells the sequencing engine that the condition is met. The same evaluation serves both wait and skip instructions. Instruction fetch is outside this block, and so is any action the engine takes on the result.

The target position comes from the upper fifteen bits of the first word. The vertical target sits in bits 15..8, and horizontal bits 7..1 of the target sit in bits 7..1. The beam value is formed the same way, as {vpos, hpos[7:1]}, so the horizontal least-significant bit is never looked at. Bits 14..1 of the second word enable the lower fourteen bits of the comparison. The top vertical bit has no enable and always takes part. Both operands are ANDed with the same mask, and the beam side must then be greater than or equal to the target side. Bit 15 of the second word is a blitter-wait disable: when it is 0, the blitter-finished flag must also be 1.

The result is registered by default, so it appears one clock after the inputs are presented. A parameter can select a purely combinational output instead.

Top module: `beam_pos_cmp`

## Requirements
- R1: With all enables set (word2[14:1] all ones), the result is 1 exactly when {vpos, hpos[7:1]} >= word1[15:1] as unsigned 15-bit values, given the blitter term is satisfied.
- R2: A comparison bit whose enable in word2 (bits 14..1, matching word1 bits 14..1) is 0 does not affect the result, on either the beam side or the target side.
- R3: The vertical MSB (word1 bit 15 against vpos[7]) always takes part: with every enable cleared, the result equals vpos[7] >= word1[15].
- R4: hpos[0] never affects the result.
- R5: When word2[15] is 0, the result is 0 unless blit_done is 1. When word2[15] is 1, blit_done has no effect.
- R6: word1[0] and word2[0], which carry the instruction type, have no effect, so wait and skip are evaluated identically.
- R7: A target of word1 = 16'hFFFF with all enables set is never met for any vpos and any hpos at or below 8'hE2.
- R8: With the default registered output, cond_met is 0 while rst_n is low and during the two cycles of synchronous reset release. After that it shows the condition for the inputs present at the previous rising clock edge.
- R9: Equality counts as met: when the masked beam value equals the masked target, the result is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word1 | input | 16 | First instruction word: target position in bits 15..1 |
| word2 | input | 16 | Second instruction word: blitter-wait disable in bit 15, enables in bits 14..1 |
| vpos | input | 8 | Current vertical beam counter |
| hpos | input | 8 | Current horizontal beam counter |
| blit_done | input | 1 | Blitter-finished flag |
| cond_met | output | 1 | Condition met, registered by default |

## Verification
Directed patterns come first. A target on a single line with the horizontal part masked off separates a correct greater-or-equal from plain equality or a reversed compare. Beam values one step either side of, and exactly on, the target expose off-by-one errors. Masked low-nibble targets and cleared enables show whether the mask is applied to both operands and whether the vertical MSB stays unmaskable. Toggling hpos[0], the type bits, and blit_done under both settings of the disable bit shows that each of these bits has exactly the reach it should. A few thousand random words and beam positions, checked against a bench model, cover mixed masks, and the end-of-list target swept over the whole visible range confirms it can never fire.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  // Beam counter widths
  localparam int unsigned V_W    = 8;
  localparam int unsigned H_W    = 8;
  // One instruction word holds the vertical field plus the horizontal field
  localparam int unsigned WORD_W = V_W + H_W;
  // Compared position: all vertical bits, horizontal without its LSB
  localparam int unsigned POS_W  = V_W + H_W - 1;
  // Enables exist for every compared bit except the top one
  localparam int unsigned EN_W   = POS_W - 1;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [EN_W-1:0]  en_t;

  typedef struct packed {
    pos_t beam;
    pos_t target;
  } cmp_ops_t;
endpackage

// File: rtl/bpc_operand_fmt.sv
module bpc_operand_fmt
  import bpc_pkg::*;
(
  input  pos_t     tgt_raw,
  input  en_t      enables,
  input  logic [V_W-1:0] vpos,
  input  logic [H_W-1:1] hpos_hi,
  output cmp_ops_t ops
);
  pos_t mask;
  pos_t beam_raw;

  assign beam_raw = {vpos, hpos_hi};

  // Per-bit mask: the most significant compared bit has no enable
  for (genvar i = 0; i < POS_W; i++) begin : g_mask
    if (i == POS_W - 1) begin : g_fixed
      assign mask[i] = 1'b1;
    end else begin : g_enabled
      assign mask[i] = enables[i];
    end
  end

  always_comb begin
    ops.beam   = beam_raw & mask;
    ops.target = tgt_raw & mask;
  end

  // R3: the top bit always reaches the comparator unmasked
  always_comb begin
    a_vmsb_r3: assert (ops.beam[POS_W-1] == vpos[V_W-1]);
  end
endmodule

// File: rtl/bpc_ge_cmp.sv
module bpc_ge_cmp #(
  parameter int unsigned WIDTH = 15
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic             ge
);
  logic [WIDTH:0] diff;

  // Unsigned greater-or-equal as "no borrow out of lhs - rhs"
  always_comb begin
    diff = {1'b0, lhs} - {1'b0, rhs};
    ge   = ~diff[WIDTH];
  end

  // R9: equal operands always compare as met
  always_comb begin
    if (lhs == rhs) a_equal_ge_r9: assert (ge);
  end
endmodule

// File: rtl/bpc_out_stage.sv
module bpc_out_stage #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  if (REG_OUT) begin : g_reg
    logic [1:0] rst_sync_q;
    logic [1:0] rst_sync_d;
    logic       live;
    logic       q_d;
    logic       q_q;

    // Reset is asserted asynchronously and released through two flops
    always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_sync_q <= '0;
      else        rst_sync_q <= rst_sync_d;
    end

    assign live = rst_sync_q[1];

    always_comb q_d = live ? d : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= 1'b0;
      else        q_q <= q_d;
    end

    assign q = q_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign q = d;
  end
endmodule

// File: rtl/beam_pos_cmp.sv
module beam_pos_cmp
  import bpc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  input  logic [V_W-1:0]    vpos,
  input  logic [H_W-1:0]    hpos,
  input  logic              blit_done,
  output logic              cond_met
);
  cmp_ops_t ops;
  logic     pos_ge;
  logic     blit_ok;
  logic     met_comb;
  logic     unused_bits;

  // Type bits and the horizontal LSB never enter the decision
  assign unused_bits = ^{word1[0], word2[0], hpos[0]};

  bpc_operand_fmt u_fmt (
    .tgt_raw (word1[WORD_W-1:1]),
    .enables (word2[WORD_W-2:1]),
    .vpos    (vpos),
    .hpos_hi (hpos[H_W-1:1]),
    .ops     (ops)
  );

  bpc_ge_cmp #(.WIDTH(POS_W)) u_cmp (
    .lhs (ops.beam),
    .rhs (ops.target),
    .ge  (pos_ge)
  );

  // Bit 15 of word 2 set means the blitter state is not consulted
  always_comb begin
    blit_ok  = word2[WORD_W-1] | blit_done;
    met_comb = pos_ge & blit_ok;
  end

  bpc_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (met_comb),
    .q     (cond_met)
  );

  p_blit_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!word2[WORD_W-1] && !blit_done) |-> !met_comb);

  p_vmsb_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vpos[V_W-1] && !word1[WORD_W-1] && blit_ok) |-> met_comb);

  p_no_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((word2[WORD_W-2:1] == '0) && blit_ok) |-> (met_comb == (vpos[V_W-1] >= word1[WORD_W-1])));

  p_end_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((word1 == '1) && (word2[WORD_W-2:1] == '1) && (hpos <= 8'hE2)) |-> !met_comb);
endmodule

// File: tb/beam_pos_cmp_test.sv
module beam_pos_cmp_test;
  logic        clk;
  logic        rst_n;
  logic [15:0] word1;
  logic [15:0] word2;
  logic [7:0]  vpos;
  logic [7:0]  hpos;
  logic        blit_done;
  logic        cond_met;

  int checks;
  int fails;
  bit done;

  beam_pos_cmp uut (
    .clk(clk), .rst_n(rst_n), .word1(word1), .word2(word2),
    .vpos(vpos), .hpos(hpos), .blit_done(blit_done), .cond_met(cond_met)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Bench model taken from the requirements
  function automatic bit model(logic [15:0] w1, logic [15:0] w2,
                               logic [7:0] v, logic [7:0] h, logic bd);
    logic [14:0] m;
    logic [14:0] b;
    logic [14:0] t;
    m = {1'b1, w2[14:1]};
    b = {v, h[7:1]} & m;
    t = w1[15:1] & m;
    return (b >= t) && (w2[15] || bd);
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cond_met=%0b expected %0b (w1=%h w2=%h v=%h h=%h bd=%0b)",
               tag, act, exp, word1, word2, vpos, hpos, blit_done);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register)
  task automatic apply(logic [15:0] w1, logic [15:0] w2, logic [7:0] v,
                       logic [7:0] h, logic bd);
    @(negedge clk);
    word1 = w1; word2 = w2; vpos = v; hpos = h; blit_done = bd;
    @(negedge clk);
  endtask

  task automatic run(logic [15:0] w1, logic [15:0] w2, logic [7:0] v,
                     logic [7:0] h, logic bd, bit exp, string tag);
    apply(w1, w2, v, h, bd);
    check(cond_met, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0107));
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    // Inputs that would satisfy the condition, held during reset
    word1 = 16'h0001; word2 = 16'hFFFE; vpos = 8'hFF; hpos = 8'hE2; blit_done = 1'b1;
    repeat (3) @(negedge clk);
    check(cond_met, 1'b0, "R8 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(cond_met, 1'b0, "R8 reset release stage 1");
    repeat (2) @(negedge clk);
    check(cond_met, 1'b1, "R8 live after release");

    // R8: one-cycle latency, output holds until the next edge
    @(negedge clk);
    vpos = 8'h00; word1 = 16'h8001; word2 = 16'hFFFE;
    #5 check(cond_met, 1'b1, "R8 holds before edge");
    @(negedge clk);
    check(cond_met, 1'b0, "R8 updates after edge");

    // R1: line wait, horizontal masked off
    run(16'h9601, 16'hFF00, 8'h96, 8'h00, 1'b0, 1'b1, "R1 line reached");
    run(16'h9601, 16'hFF00, 8'h95, 8'hE2, 1'b0, 1'b0, "R1 line not reached");
    run(16'h9601, 16'hFF00, 8'hA0, 8'h00, 1'b0, 1'b1, "R1 line passed");
    run(16'h5041, 16'hFFFE, 8'h50, 8'h3E, 1'b1, 1'b0, "R1 h one below");
    run(16'h5041, 16'hFFFE, 8'h4F, 8'hE2, 1'b1, 1'b0, "R1 earlier line");
    // R9: exact equality
    run(16'h5041, 16'hFFFE, 8'h50, 8'h40, 1'b1, 1'b1, "R9 equal position");
    // R4: hpos LSB ignored
    run(16'h5041, 16'hFFFE, 8'h50, 8'h41, 1'b1, 1'b1, "R4 hpos lsb set");
    run(16'h5043, 16'hFFFE, 8'h50, 8'h41, 1'b1, 1'b0, "R4 lsb does not carry");

    // R2: only vertical bits 3..0 enabled (word2 bits 11..8)
    run(16'h0F01, 16'h8F00, 8'h1F, 8'h00, 1'b0, 1'b1, "R2 low nibble F");
    run(16'h0F01, 16'h8F00, 8'h2E, 8'hE2, 1'b0, 1'b0, "R2 high bits masked");
    run(16'h7F01, 16'h8F00, 8'h0F, 8'h00, 1'b0, 1'b1, "R2 target bits masked");
    // R3: unmaskable vertical MSB
    run(16'h0F01, 16'h8F00, 8'h80, 8'h00, 1'b0, 1'b1, "R3 msb dominates");
    run(16'h8001, 16'h8000, 8'h7F, 8'hE2, 1'b0, 1'b0, "R3 msb required");
    run(16'h8001, 16'h8000, 8'h80, 8'h00, 1'b0, 1'b1, "R3 msb only compare");

    // R5: blitter wait term
    run(16'h0001, 16'h7FFE, 8'hFF, 8'hE2, 1'b0, 1'b0, "R5 blit busy blocks");
    run(16'h0001, 16'h7FFE, 8'hFF, 8'hE2, 1'b1, 1'b1, "R5 blit done passes");
    run(16'h0001, 16'hFFFE, 8'hFF, 8'hE2, 1'b0, 1'b1, "R5 disabled ignores busy");
    run(16'hFF01, 16'h7FFE, 8'h00, 8'h00, 1'b1, 1'b0, "R5 position still needed");

    // R6: type bits have no effect (wait vs skip)
    run(16'h6401, 16'hFF01, 8'h64, 8'h00, 1'b0, 1'b1, "R6 skip form met");
    run(16'h6400, 16'hFF00, 8'h64, 8'h00, 1'b0, 1'b1, "R6 wait form met");
    run(16'h6401, 16'hFF01, 8'h63, 8'hE2, 1'b0, 1'b0, "R6 skip form not met");
    run(16'h6400, 16'hFF00, 8'h63, 8'hE2, 1'b0, 1'b0, "R6 wait form not met");

    // R7: end-of-list marker never fires over the whole visible range
    for (int v = 0; v < 256; v += 5) begin
      for (int h = 0; h <= 8'hE2; h += 17) begin
        run(16'hFFFF, 16'hFFFE, v[7:0], h[7:0], 1'b1, 1'b0, "R7 end marker");
      end
    end
    run(16'hFFFF, 16'hFFFE, 8'hFF, 8'hE2, 1'b1, 1'b0, "R7 end marker corner");

    // R1/R2/R9: random words and positions against the model
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] w1;
      logic [15:0] w2;
      logic [7:0]  v;
      logic [7:0]  h;
      logic        bd;
      w1 = 16'($urandom);
      w2 = 16'($urandom);
      v  = 8'($urandom);
      h  = 8'($urandom);
      bd = 1'($urandom);
      if (n % 4 == 0) w2[14:1] = '1;
      if (n % 8 == 1) begin v = w1[15:8]; h = {w1[7:1], 1'($urandom)}; end
      run(w1, w2, v, h, bd, model(w1, w2, v, h, bd), "R1 R2 random");
    end

    finish_run();
  end
endmodule